// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Controller

This block sits between a processor's load/store port and a slower main memory. It keeps a direct-mapped array of lines, each holding a valid flag, a dirty flag, a tag and a block of words. Reads and writes that hit are completed from the array alone. Write hits change only the cached copy and mark the line as modified. Main memory is brought up to date only when a modified line has to be replaced.

On any miss the controller walks a short sequence. If the victim line is valid and dirty, it first copies every word of that line back to memory at the victim's own address. It then reads the new block word by word and repeats the tag lookup, which now hits. A mode input that is sampled with each request controls write misses. With allocation on, the line is filled and then written. With allocation off, the single word goes straight to memory and the cached line stays exactly as it was.

The memory side is a single word-wide request/response port. A request is held with stable address, direction and data until the memory returns a one-cycle acknowledge. The CPU side accepts one access at a time. It shows `cpu_ready` while idle and pulses `cpu_done` when the access completes.

Top module: `wb_cache_ctrl`

## Requirements
- R1: While reset is low and in the cycle after it, `cpu_ready` is 1 and `mem_req` and `cpu_done` are 0. Reset clears every valid and dirty flag, so an access after reset misses and writes nothing back.
- R2: A read miss to an invalid or clean line issues exactly WORDS memory reads (`mem_we`=0) at the line-aligned addresses with word offsets 0,1,...,WORDS-1 in that order, and returns the addressed word on `cpu_rdata` with `cpu_done`. The address layout is {tag, index, word offset}, with the word offset in the low bits.
- R3: A read hit returns the cached word and makes no memory request.
- R4: A write hit makes no memory request and leaves memory unchanged. A later read of that address returns the written value.
- R5: A miss whose line is valid and dirty first issues WORDS memory writes of the old line at {old tag, index, offset 0..WORDS-1}, carrying the current cached data. Only after that does it make its first read of the new block.
- R6: A miss whose line is valid and clean makes no memory write.
- R7: With `wr_alloc`=1, a write miss fills the line with WORDS reads and no memory write, then stores the data in the cache and marks the line dirty. Evicting that line later writes the new value back.
- R8: With `wr_alloc`=0, a write miss issues exactly one memory write of `cpu_wdata` to `cpu_addr`. It leaves the line's data, tag and valid flag unchanged, so the previously cached block still hits and a line that was invalid stays invalid.
- R9: `cpu_ready` is 1 only while idle and never together with `mem_req` or `cpu_done`. `cpu_done` lasts one cycle and never directly follows a cycle with `cpu_ready` high.
- R10: While `mem_req` is high without `mem_ack`, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` keep their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_req | input | 1 | Access request, taken when `cpu_ready` is high |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address {tag, index, offset} |
| cpu_wdata | input | DATA_W | Write data |
| wr_alloc | input | 1 | Write-miss mode: 1 = allocate, 0 = write around |
| cpu_ready | output | 1 | Idle and able to take a request |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_done` on reads |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | One-cycle acknowledge from memory |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` |

## Verification
A lost or stale dirty flag shows only at the next eviction of that line. Either the writeback burst is missing, so the memory model keeps an old value that a later read miss returns, or an extra burst appears after a clean line. The bench therefore follows each modifying write with a forced conflict and a re-read. A wrong tag or valid update shows on the very next access to that index, either as memory traffic where a hit was due or as a wrong `cpu_rdata`. Counting memory operations per access catches both within one transaction.

// File: rtl/wbc_pkg.sv
// Package for the write-back cache controller: state encoding shared by
// the sequencer and visible to anything that inspects it.
package wbc_pkg;

    // Sequencer states; AROUND carries a write miss straight to memory.
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_COMPARE   = 3'd1,
        ST_WRITEBACK = 3'd2,
        ST_ALLOCATE  = 3'd3,
        ST_AROUND    = 3'd4,
        ST_RESPOND   = 3'd5
    } ctrl_state_t;

endpackage

// File: rtl/wbc_tag_store.sv
// Tag store: per-line valid, dirty and tag registers with one combinational
// read port. Assumes fill and dirty-set never target conflicting meanings
// in the same cycle (the sequencer issues them in different states).
module wbc_tag_store #(
    parameter int LINES = 16,
    parameter int TAG_W = 10,
    localparam int INDEX_W = $clog2(LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INDEX_W-1:0] line_idx,
    input  logic               fill_en,
    input  logic [TAG_W-1:0]   fill_tag,
    input  logic               dirty_set,
    output logic               rd_valid,
    output logic               rd_dirty,
    output logic [TAG_W-1:0]   rd_tag
);

    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;
    logic [TAG_W-1:0] tag_q [LINES];

    // Per-line state flags, cleared by reset, set by fill or write hit.
    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    valid_q[g] <= 1'b0;
                    dirty_q[g] <= 1'b0;
                end else if (fill_en && line_idx == INDEX_W'(g)) begin
                    valid_q[g] <= 1'b1;
                    dirty_q[g] <= 1'b0;
                end else if (dirty_set && line_idx == INDEX_W'(g)) begin
                    dirty_q[g] <= 1'b1;
                end
            end

            // Tag capture on fill; needs no reset because valid guards it.
            always_ff @(posedge clk) begin
                if (fill_en && line_idx == INDEX_W'(g)) begin
                    tag_q[g] <= fill_tag;
                end
            end
        end
    endgenerate

    // Combinational lookup of the addressed line.
    always_comb begin
        rd_valid = valid_q[line_idx];
        rd_dirty = dirty_q[line_idx];
        rd_tag   = tag_q[line_idx];
    end

endmodule

// File: rtl/wbc_data_store.sv
// Data store: LINES x WORDS words with one write port and one combinational
// read port sharing a line index. Contents are undefined until filled.
module wbc_data_store #(
    parameter int LINES  = 16,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    localparam int INDEX_W = $clog2(LINES),
    localparam int OFF_W   = $clog2(WORDS)
) (
    input  logic               clk,
    input  logic [INDEX_W-1:0] line_idx,
    input  logic               wr_en,
    input  logic [OFF_W-1:0]   wr_off,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [OFF_W-1:0]   rd_off,
    output logic [DATA_W-1:0]  rd_data
);

    logic [DATA_W-1:0] mem_q [LINES][WORDS];

    // Single-word write into the addressed line.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[line_idx][wr_off] <= wr_data;
        end
    end

    // Combinational word read.
    always_comb begin
        rd_data = mem_q[line_idx][rd_off];
    end

endmodule

// File: rtl/wbc_ctrl.sv
// Access sequencer: takes one CPU request at a time, looks up the tag,
// and walks writeback, refill or write-around over the memory port.
// Assumes memory holds mem_rdata valid only in the mem_ack cycle and
// that each request receives exactly one acknowledge.
module wbc_ctrl
    import wbc_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    parameter int INDEX_W = 4,
    parameter int OFF_W   = 2,
    localparam int TAG_W  = ADDR_W - INDEX_W - OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [DATA_W-1:0]  cpu_wdata,
    input  logic               wr_alloc,
    output logic               cpu_ready,
    output logic               cpu_done,
    output logic [DATA_W-1:0]  cpu_rdata,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic               mem_ack,
    input  logic [DATA_W-1:0]  mem_rdata,
    input  logic               tag_valid,
    input  logic               tag_dirty,
    input  logic [TAG_W-1:0]   tag_q,
    input  logic [DATA_W-1:0]  line_word,
    output logic [INDEX_W-1:0] line_idx,
    output logic [OFF_W-1:0]   rd_off,
    output logic               ds_we,
    output logic [OFF_W-1:0]   ds_off,
    output logic [DATA_W-1:0]  ds_wdata,
    output logic               fill_en,
    output logic [TAG_W-1:0]   fill_tag,
    output logic               dirty_set
);

    ctrl_state_t       state_q, state_d;
    logic              req_we_q;
    logic              req_alloc_q;
    logic [ADDR_W-1:0] req_addr_q;
    logic [DATA_W-1:0] req_wdata_q;
    logic [OFF_W-1:0]  cnt_q;
    logic [DATA_W-1:0] rdata_q;

    logic [TAG_W-1:0]  req_tag;
    logic [OFF_W-1:0]  req_off;
    logic              hit;
    logic              last_word;

    // Field split of the latched request and lookup result.
    always_comb begin
        req_tag   = req_addr_q[ADDR_W-1 -: TAG_W];
        req_off   = req_addr_q[OFF_W-1:0];
        line_idx  = req_addr_q[OFF_W +: INDEX_W];
        hit       = tag_valid && (tag_q == req_tag);
        last_word = &cnt_q;
    end

    // Next-state selection for the access sequence.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:      if (cpu_req) state_d = ST_COMPARE;
            ST_COMPARE: begin
                if (hit)                          state_d = ST_RESPOND;
                else if (req_we_q && !req_alloc_q) state_d = ST_AROUND;
                else if (tag_valid && tag_dirty)  state_d = ST_WRITEBACK;
                else                              state_d = ST_ALLOCATE;
            end
            ST_WRITEBACK: if (mem_ack && last_word) state_d = ST_ALLOCATE;
            ST_ALLOCATE:  if (mem_ack && last_word) state_d = ST_COMPARE;
            ST_AROUND:    if (mem_ack) state_d = ST_RESPOND;
            ST_RESPOND:   state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request capture when a new access is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_we_q    <= 1'b0;
            req_alloc_q <= 1'b0;
            req_addr_q  <= '0;
            req_wdata_q <= '0;
        end else if (state_q == ST_IDLE && cpu_req) begin
            req_we_q    <= cpu_we;
            req_alloc_q <= wr_alloc;
            req_addr_q  <= cpu_addr;
            req_wdata_q <= cpu_wdata;
        end
    end

    // Word counter for burst writeback and refill; wraps after the last word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_q == ST_COMPARE) begin
            cnt_q <= '0;
        end else if ((state_q == ST_WRITEBACK || state_q == ST_ALLOCATE) && mem_ack) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Read data capture on a read hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (state_q == ST_COMPARE && hit && !req_we_q) begin
            rdata_q <= line_word;
        end
    end

    // CPU-side handshake outputs.
    always_comb begin
        cpu_ready = (state_q == ST_IDLE);
        cpu_done  = (state_q == ST_RESPOND);
        cpu_rdata = rdata_q;
    end

    // Memory-side request: victim burst, refill burst or single write-around.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state_q)
            ST_WRITEBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {tag_q, line_idx, cnt_q};
                mem_wdata = line_word;
            end
            ST_ALLOCATE: begin
                mem_req   = 1'b1;
                mem_addr  = {req_tag, line_idx, cnt_q};
            end
            ST_AROUND: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = req_addr_q;
                mem_wdata = req_wdata_q;
            end
            default: ;
        endcase
    end

    // Array update controls: refill words, write-hit merge, tag and dirty.
    always_comb begin
        rd_off    = (state_q == ST_WRITEBACK) ? cnt_q : req_off;
        ds_we     = (state_q == ST_COMPARE && hit && req_we_q)
                 || (state_q == ST_ALLOCATE && mem_ack);
        ds_off    = (state_q == ST_ALLOCATE) ? cnt_q : req_off;
        ds_wdata  = (state_q == ST_ALLOCATE) ? mem_rdata : req_wdata_q;
        fill_en   = (state_q == ST_ALLOCATE) && mem_ack && last_word;
        fill_tag  = req_tag;
        dirty_set = (state_q == ST_COMPARE) && hit && req_we_q;
    end

endmodule

// File: rtl/wb_cache_ctrl.sv
// Direct-mapped write-back cache controller top: ties the sequencer to the
// tag and data stores. Requires WORDS >= 2 and power-of-two LINES/WORDS.
module wb_cache_ctrl #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int LINES  = 16,
    parameter int WORDS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              wr_alloc,
    output logic              cpu_ready,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int INDEX_W = $clog2(LINES);
    localparam int OFF_W   = $clog2(WORDS);
    localparam int TAG_W   = ADDR_W - INDEX_W - OFF_W;

    logic               tag_valid;
    logic               tag_dirty;
    logic [TAG_W-1:0]   tag_rd;
    logic [DATA_W-1:0]  line_word;
    logic [INDEX_W-1:0] line_idx;
    logic [OFF_W-1:0]   rd_off;
    logic               ds_we;
    logic [OFF_W-1:0]   ds_off;
    logic [DATA_W-1:0]  ds_wdata;
    logic               fill_en;
    logic [TAG_W-1:0]   fill_tag;
    logic               dirty_set;

    wbc_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .INDEX_W(INDEX_W),
        .OFF_W  (OFF_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_req  (cpu_req),
        .cpu_we   (cpu_we),
        .cpu_addr (cpu_addr),
        .cpu_wdata(cpu_wdata),
        .wr_alloc (wr_alloc),
        .cpu_ready(cpu_ready),
        .cpu_done (cpu_done),
        .cpu_rdata(cpu_rdata),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .mem_ack  (mem_ack),
        .mem_rdata(mem_rdata),
        .tag_valid(tag_valid),
        .tag_dirty(tag_dirty),
        .tag_q    (tag_rd),
        .line_word(line_word),
        .line_idx (line_idx),
        .rd_off   (rd_off),
        .ds_we    (ds_we),
        .ds_off   (ds_off),
        .ds_wdata (ds_wdata),
        .fill_en  (fill_en),
        .fill_tag (fill_tag),
        .dirty_set(dirty_set)
    );

    wbc_tag_store #(
        .LINES(LINES),
        .TAG_W(TAG_W)
    ) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_idx (line_idx),
        .fill_en  (fill_en),
        .fill_tag (fill_tag),
        .dirty_set(dirty_set),
        .rd_valid (tag_valid),
        .rd_dirty (tag_dirty),
        .rd_tag   (tag_rd)
    );

    wbc_data_store #(
        .LINES (LINES),
        .WORDS (WORDS),
        .DATA_W(DATA_W)
    ) u_data (
        .clk     (clk),
        .line_idx(line_idx),
        .wr_en   (ds_we),
        .wr_off  (ds_off),
        .wr_data (ds_wdata),
        .rd_off  (rd_off),
        .rd_data (line_word)
    );

endmodule

// File: rtl/wbc_checker.sv
// Port-level protocol checker for wb_cache_ctrl, attached by bind.
// Assumes the environment drives rst_n low from time zero.
module wbc_checker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_ready,
    input logic              cpu_done,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ack
);

    // R1: reset forces the idle handshake state.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (cpu_ready && !mem_req && !cpu_done));

    // R9: no memory traffic or completion while idle.
    assert_ready_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> (!mem_req && !cpu_done));

    // R9: completion lasts a single cycle.
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

    // R9: completion always follows at least one lookup cycle.
    assert_done_after_lookup_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |-> !$past(cpu_ready));

    // R10: an unacknowledged memory request holds steady.
    assert_req_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)
                                   && $stable(mem_we) && $stable(mem_wdata)));

endmodule

bind wb_cache_ctrl wbc_checker #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_wbc_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_ready(cpu_ready),
    .cpu_done (cpu_done),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_ack  (mem_ack)
);

// File: tb/test_wb_cache_ctrl.sv
// Scoreboard bench: access task pushes expected read data, a monitor pops
// and compares on cpu_done; a latency memory model logs every operation.
module test_wb_cache_ctrl;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int LAT    = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_req = 1'b0;
    logic              cpu_we = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [DATA_W-1:0] cpu_wdata = '0;
    logic              wr_alloc = 1'b1;
    logic              cpu_ready;
    logic              cpu_done;
    logic [DATA_W-1:0] cpu_rdata;
    logic              mem_req;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic              mem_ack = 1'b0;
    logic [DATA_W-1:0] mem_rdata = '0;

    int vectors = 0;
    int fails = 0;
    int done_seen = 0;

    always #5 clk = ~clk;

    wb_cache_ctrl i_wb_cache_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .wr_alloc(wr_alloc),
        .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // Memory contents and the coherent view the CPU must observe.
    logic [DATA_W-1:0] mem_model [logic [ADDR_W-1:0]];
    logic [DATA_W-1:0] ref_model [logic [ADDR_W-1:0]];
    bit                op_we [$];
    logic [ADDR_W-1:0] op_addr [$];
    logic [DATA_W-1:0] op_data [$];
    int                op_base = 0;

    function automatic logic [DATA_W-1:0] init_val(logic [ADDR_W-1:0] a);
        return {a ^ 16'h5A3C, a};
    endfunction

    function automatic logic [DATA_W-1:0] mem_get(logic [ADDR_W-1:0] a);
        if (mem_model.exists(a)) return mem_model[a];
        return init_val(a);
    endfunction

    function automatic logic [DATA_W-1:0] ref_get(logic [ADDR_W-1:0] a);
        if (ref_model.exists(a)) return ref_model[a];
        return init_val(a);
    endfunction

    // Address builder: {tag[9:0], index[3:0], offset[1:0]}.
    function automatic logic [ADDR_W-1:0] mk(int tag, int idx, int off);
        return {10'(tag), 4'(idx), 2'(off)};
    endfunction

    // Fixed-latency memory model, driven on the falling edge.
    bit                m_busy = 1'b0;
    int                m_cnt = 0;
    bit                m_we;
    logic [ADDR_W-1:0] m_addr;
    logic [DATA_W-1:0] m_wdata;
    always @(negedge clk) begin
        if (m_busy) begin
            if (m_cnt == LAT - 1) begin
                mem_ack = 1'b1;
                if (m_we) mem_model[m_addr] = m_wdata;
                mem_rdata = m_we ? '0 : mem_get(m_addr);
                op_we.push_back(m_we);
                op_addr.push_back(m_addr);
                op_data.push_back(m_wdata);
                m_busy = 1'b0;
            end else begin
                m_cnt++;
            end
        end else if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (rst_n && mem_req) begin
            m_busy  = 1'b1;
            m_cnt   = 0;
            m_we    = mem_we;
            m_addr  = mem_addr;
            m_wdata = mem_wdata;
        end
    end

    task automatic chk(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Scoreboard: expected read results queued by the driver.
    bit                exp_rd [$];
    logic [DATA_W-1:0] exp_dat [$];
    string             exp_req [$];

    always @(negedge clk) begin
        if (rst_n && cpu_done) begin
            if (exp_rd.size() == 0) begin
                chk("R9 unexpected done", 32'd1, 32'd0);
            end else begin
                bit                r = exp_rd.pop_front();
                logic [DATA_W-1:0] d = exp_dat.pop_front();
                string             q = exp_req.pop_front();
                if (r) chk(q, cpu_rdata, d);
            end
            done_seen++;
        end
    end

    task automatic access(bit we, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] wd,
                          bit alloc, string req);
        int target;
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        target = done_seen + 1;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; wr_alloc = alloc;
        exp_rd.push_back(!we);
        exp_dat.push_back(ref_get(a));
        exp_req.push_back(req);
        if (we) ref_model[a] = wd;
        @(negedge clk);
        cpu_req = 1'b0;
        chk("R9 busy ready low", 32'(cpu_ready), 32'd0);
        while (done_seen < target) @(negedge clk);
    endtask

    task automatic mark();
        op_base = op_we.size();
    endtask

    task automatic chk_ops(string req, int n_rd, int n_wr);
        int r = 0;
        int w = 0;
        for (int i = op_base; i < op_we.size(); i++) begin
            if (op_we[i]) w++; else r++;
        end
        chk({req, " reads"}, 32'(r), 32'(n_rd));
        chk({req, " writes"}, 32'(w), 32'(n_wr));
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: idle handshake during reset.
        chk("R1 ready in reset", 32'(cpu_ready), 32'd1);
        chk("R1 mem_req in reset", 32'(mem_req), 32'd0);
        chk("R1 done in reset", 32'(cpu_done), 32'd0);
        rst_n = 1'b1;

        // R2: read miss to invalid line, four ordered reads.
        mark();
        access(1'b0, mk(1, 2, 1), '0, 1'b1, "R2 read miss data");
        chk_ops("R2 cold miss", 4, 0);
        for (int k = 0; k < 4; k++)
            chk("R2 fill order", 32'(op_addr[op_base + k]), 32'(mk(1, 2, k)));

        // R3: read hit, no memory.
        mark();
        access(1'b0, mk(1, 2, 3), '0, 1'b1, "R3 hit data");
        chk_ops("R3 hit", 0, 0);

        // R4: write hit stays in cache.
        mark();
        access(1'b1, mk(1, 2, 1), 32'hDEAD_0001, 1'b1, "R4 write");
        chk_ops("R4 write hit", 0, 0);
        chk("R4 memory untouched", mem_get(mk(1, 2, 1)), init_val(mk(1, 2, 1)));
        access(1'b0, mk(1, 2, 1), '0, 1'b1, "R4 read back");

        // R5: dirty eviction writes back before refill.
        mark();
        access(1'b0, mk(5, 2, 0), '0, 1'b1, "R5 new block data");
        chk_ops("R5 dirty miss", 4, 4);
        for (int k = 0; k < 4; k++) begin
            chk("R5 writeback first", 32'(op_we[op_base + k]), 32'd1);
            chk("R5 writeback addr", 32'(op_addr[op_base + k]), 32'(mk(1, 2, k)));
        end
        chk("R5 dirty word stored", mem_get(mk(1, 2, 1)), 32'hDEAD_0001);

        // R6: clean eviction, no writeback.
        mark();
        access(1'b0, mk(7, 2, 2), '0, 1'b1, "R6 clean miss data");
        chk_ops("R6 clean miss", 4, 0);

        // R7: write miss with allocation.
        mark();
        access(1'b1, mk(3, 4, 2), 32'hBEEF_0002, 1'b1, "R7 write");
        chk_ops("R7 alloc fill", 4, 0);
        chk("R7 memory untouched", mem_get(mk(3, 4, 2)), init_val(mk(3, 4, 2)));
        mark();
        access(1'b0, mk(3, 4, 2), '0, 1'b1, "R7 read back");
        chk_ops("R7 now hit", 0, 0);
        mark();
        access(1'b0, mk(9, 4, 0), '0, 1'b1, "R7 evict read");
        chk_ops("R7 dirty evict", 4, 4);
        chk("R7 written back", mem_get(mk(3, 4, 2)), 32'hBEEF_0002);

        // R8: write-around leaves the cached line alone.
        access(1'b0, mk(2, 6, 0), '0, 1'b1, "R8 prefill");
        mark();
        access(1'b1, mk(4, 6, 1), 32'hCAFE_0003, 1'b0, "R8 write");
        chk_ops("R8 around", 0, 1);
        chk("R8 around addr", 32'(op_addr[op_base]), 32'(mk(4, 6, 1)));
        chk("R8 around data", op_data[op_base], 32'hCAFE_0003);
        mark();
        access(1'b0, mk(2, 6, 3), '0, 1'b1, "R8 old line hit");
        chk_ops("R8 line kept", 0, 0);
        mark();
        access(1'b0, mk(4, 6, 1), '0, 1'b1, "R8 read around data");
        chk_ops("R8 later miss clean", 4, 0);
        mark();
        access(1'b1, mk(1, 9, 0), 32'h1234_5678, 1'b0, "R8 write invalid line");
        access(1'b0, mk(1, 9, 0), '0, 1'b1, "R8 invalid stays invalid");
        chk_ops("R8 invalid line", 4, 1);

        // Conflict ping-pong with writes on one index.
        for (int i = 0; i < 6; i++) begin
            access(1'b1, mk(10, 13, i % 4), 32'hA000_0000 + 32'(i), 1'b1, "R5 pingpong write");
            access(1'b0, mk(11, 13, (i + 1) % 4), '0, 1'b1, "R5 pingpong other");
            access(1'b0, mk(10, 13, i % 4), '0, 1'b1, "R5 pingpong reread");
        end

        // R1: reset drops dirty state.
        access(1'b1, mk(1, 11, 0), 32'h0BAD_0004, 1'b1, "R1 pre-reset write");
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        ref_model[mk(1, 11, 0)] = mem_get(mk(1, 11, 0));
        mark();
        access(1'b0, mk(1, 11, 0), '0, 1'b1, "R1 after reset data");
        chk_ops("R1 after reset miss", 4, 0);

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule